// File: doc/BRIEF.md
# Frequency-Change Watchdog with Recovery

This block protects a system against a frequency change that leaves it hung. Software first arms the guard by writing a nonzero 4-bit timeout selector, then applies a new frequency, either by choosing a new entry of the frequency-select code or by loading new divider values. The clock logic reports that change on a one-cycle strobe, and the guard then starts counting down the selected time. If the new frequency works, software writes zero to the selector before the count runs out. That cancels the guard, and the new setting stays in place.

If software never clears the selector, the count expires. On expiry the guard sets an alarm flag and drives an active-low system reset pulse of fixed length. It also issues a one-cycle restore strobe that tells the clock logic which frequency source to fall back to. A recovery bit picks that source: 0 means the strap selection latched at power-up, and 1 means the last software-programmed selection. A reload bit lets software extend the time while the count is running. Only a 0-to-1 change of the written reload value has an effect.

Time is measured with a time-base tick. A parameterised prescaler turns these ticks into 2-second units, so one selector step equals `TICKS_PER_UNIT` ticks. The reset pulse length is set in ticks by `RST_TICKS`.

Top module: `fcw_guard`

## Requirements
- R1: When the timeout selector is 0000, a frequency-change strobe does not start the guard, and no alarm, reset pulse or restore strobe follows.
- R2: A frequency-change strobe taken with a nonzero selector k starts a count of k·TICKS_PER_UNIT ticks. A tick in the strobe's own cycle is not counted. The count expires on the cycle that samples the last of those ticks.
- R3: Writing 0000 to the selector while counting cancels the guard: no alarm, no reset pulse and no restore strobe.
- R4: On expiry, alarm_o goes to 1 and wd_rst_n_o goes low on the same clock edge. wd_rst_n_o stays low until RST_TICKS further ticks have been sampled. The tick in the expiry cycle is not counted.
- R5: alarm_o stays 1 until a cycle samples the selector at 0000. It then reads 0 from the next cycle on.
- R6: While counting, a 0-to-1 change of reload_i restarts the full count from the current selector. Holding reload_i at 1 causes no further restart. A reload edge while idle starts nothing.
- R7: On expiry, restore_stb_o is high for exactly one cycle. restore_sw_o then holds the recovery bit sampled in the expiry cycle: 0 selects the strap setting and 1 selects the software setting.
- R8: A frequency-change strobe while counting restarts the full count. This also holds when it falls in the same cycle as the tick that would have expired the count, and in that case no expiry occurs.
- R9: After an expiry, frequency-change strobes are ignored until the selector has been sampled at 0000 and the reset pulse has ended.
- R10: After reset, alarm_o = 0, wd_rst_n_o = 1, restore_stb_o = 0 and restore_sw_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Time-base tick, one cycle wide |
| freq_chg_i | input | 1 | Strobe: a new frequency selection or divider setting was applied |
| tmo_sel_i | input | SEL_W | Timeout selector; 0 disarms, k means k units of 2 s |
| reload_i | input | 1 | Reload bit; acts on a 0-to-1 change |
| recov_sel_i | input | 1 | Recovery source: 0 strap setting, 1 software setting |
| alarm_o | output | 1 | Timeout alarm flag |
| wd_rst_n_o | output | 1 | Active-low system reset pulse |
| restore_stb_o | output | 1 | One-cycle strobe asking for the frequency source to be restored |
| restore_sw_o | output | 1 | Source to restore: 0 strap, 1 software |

## Verification
The key collision is a restart, caused by a frequency-change strobe or a reload edge, landing in the same cycle as the tick that would end the count. The bench provokes it by watching its own model until exactly one tick remains. It then drives the strobe and a tick together. It judges the result by seeing no restore strobe in that cycle, and an expiry exactly one full timeout of ticks later. A second overlap is a strobe arriving while the alarm is still set or the reset pulse is still active. The bench checks that no second expiry follows until the selector has been cleared and rearmed.

// File: rtl/fcw_pkg.sv
package fcw_pkg;

    typedef enum logic {
        WD_IDLE = 1'b0,
        WD_RUN  = 1'b1
    } wd_st_e;

endpackage

// File: rtl/fcw_prescale.sv
module fcw_prescale #(
    parameter int TICKS_PER_UNIT = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic run_i,
    input  logic tick_i,
    output logic unit_stb_o
);

    localparam int PRE_W = (TICKS_PER_UNIT > 1) ? $clog2(TICKS_PER_UNIT) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_UNIT - 1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_s;

    pre_s pre_d, pre_q;
    logic wrap;

    always_comb begin
        pre_d = pre_q;
        wrap  = run_i && !clr_i && tick_i && (pre_q.pre == PRE_LAST);
        if (clr_i || !run_i) begin
            pre_d.pre = '0;
        end else if (tick_i) begin
            pre_d.pre = wrap ? '0 : pre_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    assign unit_stb_o = wrap;

    AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q.pre <= PRE_LAST); // R2

    AST_PRE_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (pre_q.pre == '0)); // R2

endmodule

// File: rtl/fcw_units.sv
module fcw_units #(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [SEL_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic             last_o
);

    typedef struct packed {
        logic [SEL_W-1:0] cnt;
    } unit_s;

    unit_s unit_d, unit_q;

    always_comb begin
        unit_d = unit_q;
        if (load_i) begin
            unit_d.cnt = load_val_i;
        end else if (dec_i && (unit_q.cnt != '0)) begin
            unit_d.cnt = unit_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) unit_q <= '0;
        else        unit_q <= unit_d;
    end

    assign last_o = (unit_q.cnt == SEL_W'(1));

    AST_UNIT_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !load_i) |-> (unit_q.cnt != '0)); // R2

endmodule

// File: rtl/fcw_rstpulse.sv
module fcw_rstpulse #(
    parameter int RST_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic tick_i,
    output logic active_o
);

    localparam int CNT_W = (RST_TICKS > 1) ? $clog2(RST_TICKS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RST_TICKS - 1);

    typedef struct packed {
        logic             act;
        logic [CNT_W-1:0] cnt;
    } pls_s;

    pls_s pls_d, pls_q;

    always_comb begin
        pls_d = pls_q;
        if (start_i) begin
            pls_d.act = 1'b1;
            pls_d.cnt = '0;
        end else if (pls_q.act && tick_i) begin
            if (pls_q.cnt == CNT_LAST) begin
                pls_d.act = 1'b0;
                pls_d.cnt = '0;
            end else begin
                pls_d.cnt = pls_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pls_q <= '0;
        else        pls_q <= pls_d;
    end

    assign active_o = pls_q.act;

    AST_PULSE_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !pls_q.act); // R9

    AST_PULSE_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (pls_q.act && !tick_i) |=> pls_q.act); // R4

endmodule

// File: rtl/fcw_guard.sv
module fcw_guard
    import fcw_pkg::*;
#(
    parameter int SEL_W          = 4,
    parameter int TICKS_PER_UNIT = 2000,
    parameter int RST_TICKS      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             freq_chg_i,
    input  logic [SEL_W-1:0] tmo_sel_i,
    input  logic             reload_i,
    input  logic             recov_sel_i,
    output logic             alarm_o,
    output logic             wd_rst_n_o,
    output logic             restore_stb_o,
    output logic             restore_sw_o
);

    typedef struct packed {
        wd_st_e st;
        logic   alarm;
        logic   rld;
        logic   stb;
        logic   sw;
    } grd_s;

    grd_s grd_d, grd_q;

    logic sel_nz, rld_rise, in_run;
    logic start, restart, load, expire;
    logic unit_stb, unit_last, pulse_act;

    assign sel_nz   = |tmo_sel_i;
    assign rld_rise = reload_i && !grd_q.rld;
    assign in_run   = (grd_q.st == WD_RUN);
    // Arming: nonzero selector, no pending alarm, reset pulse finished
    assign start    = !in_run && freq_chg_i && sel_nz && !grd_q.alarm && !pulse_act;
    // Restart outranks the final tick; cancel outranks both
    assign restart  = in_run && sel_nz && (freq_chg_i || rld_rise);
    assign load     = start || restart;
    assign expire   = in_run && sel_nz && !restart && unit_stb && unit_last;

    fcw_prescale #(
        .TICKS_PER_UNIT (TICKS_PER_UNIT)
    ) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (load),
        .run_i      (in_run),
        .tick_i     (tick_i),
        .unit_stb_o (unit_stb)
    );

    fcw_units #(
        .SEL_W (SEL_W)
    ) u_units (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .load_val_i (tmo_sel_i),
        .dec_i      (unit_stb),
        .last_o     (unit_last)
    );

    fcw_rstpulse #(
        .RST_TICKS (RST_TICKS)
    ) u_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (expire),
        .tick_i   (tick_i),
        .active_o (pulse_act)
    );

    always_comb begin
        grd_d     = grd_q;
        grd_d.rld = reload_i;
        grd_d.stb = expire;
        if (expire) grd_d.sw = recov_sel_i;

        unique case (grd_q.st)
            WD_IDLE: if (start) grd_d.st = WD_RUN;
            WD_RUN:  if (!sel_nz || expire) grd_d.st = WD_IDLE;
            default: grd_d.st = WD_IDLE;
        endcase

        if (expire)       grd_d.alarm = 1'b1;
        else if (!sel_nz) grd_d.alarm = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) grd_q <= '0;
        else        grd_q <= grd_d;
    end

    assign alarm_o       = grd_q.alarm;
    assign wd_rst_n_o    = !pulse_act;
    assign restore_stb_o = grd_q.stb;
    assign restore_sw_o  = grd_q.sw;

    AST_IDLE_WHEN_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_run && !sel_nz) |=> (grd_q.st == WD_IDLE)); // R1

    AST_CANCEL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && !sel_nz) |=> ((grd_q.st == WD_IDLE) && !restore_stb_o)); // R3

    AST_RST_WITH_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wd_rst_n_o) |-> (alarm_o && restore_stb_o)); // R4

    AST_ALARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_nz |=> !alarm_o); // R5

    AST_RELOAD_KEEPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && sel_nz && rld_rise) |=> ((grd_q.st == WD_RUN) && !restore_stb_o)); // R6

    AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        restore_stb_o |=> !restore_stb_o); // R7

    AST_CHG_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && sel_nz && freq_chg_i) |=> ((grd_q.st == WD_RUN) && !restore_stb_o)); // R8

    AST_NO_START_IN_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_run && alarm_o) |=> (grd_q.st == WD_IDLE)); // R9

endmodule

// File: tb/tb_fcw_guard.sv
module tb_fcw_guard;

    localparam int TPU = 4;
    localparam int RT  = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       freq_chg = 1'b0;
    logic [3:0] tmo_sel = 4'd0;
    logic       reload = 1'b0;
    logic       recov = 1'b0;
    logic       alarm_o, wd_rst_n_o, restore_stb_o, restore_sw_o;

    always #2 clk = ~clk;

    fcw_guard #(
        .SEL_W          (4),
        .TICKS_PER_UNIT (TPU),
        .RST_TICKS      (RT)
    ) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_i        (tick),
        .freq_chg_i    (freq_chg),
        .tmo_sel_i     (tmo_sel),
        .reload_i      (reload),
        .recov_sel_i   (recov),
        .alarm_o       (alarm_o),
        .wd_rst_n_o    (wd_rst_n_o),
        .restore_stb_o (restore_stb_o),
        .restore_sw_o  (restore_sw_o)
    );

    int  n_chk = 0, n_fail = 0;
    int  n_stb = 0, tk_cnt = 0, t0 = 0, t_exp = 0, pulse_ticks = 0;
    int  tph = 0;
    bit  rst_low_now = 0, done = 0;

    // Behavioural reference: ticks remaining as a plain integer
    bit m_run, m_alarm, m_stb, m_sw, m_prev;
    int m_left, m_pulse;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_left = 0; m_alarm = 0; m_stb = 0;
            m_sw = 0; m_pulse = 0; m_prev = 0;
        end else begin
            bit nz, rise, ex, pact;
            nz   = (tmo_sel != 0);
            rise = reload && !m_prev;
            ex   = 0;
            pact = (m_pulse > 0);
            if (m_run) begin
                if (!nz) m_run = 0;
                else if (freq_chg || rise) m_left = int'(tmo_sel) * TPU;
                else if (tick) begin
                    m_left = m_left - 1;
                    if (m_left == 0) begin ex = 1; m_run = 0; end
                end
            end else if (freq_chg && nz && !m_alarm && !pact) begin
                m_run  = 1;
                m_left = int'(tmo_sel) * TPU;
            end
            if (ex) m_pulse = RT;
            else if (pact && tick) m_pulse = m_pulse - 1;
            if (ex) m_alarm = 1;
            else if (!nz) m_alarm = 0;
            m_stb = ex;
            if (ex) m_sw = recov;
            m_prev = reload;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic nxt();
        @(negedge clk);
        check("R4/R5 alarm vs model", int'(alarm_o), int'(m_alarm));
        check("R4 reset pulse vs model", int'(wd_rst_n_o), (m_pulse > 0) ? 0 : 1);
        check("R7 restore strobe vs model", int'(restore_stb_o), int'(m_stb));
        check("R7 restore source vs model", int'(restore_sw_o), int'(m_sw));
        if (restore_stb_o) begin n_stb++; t_exp = tk_cnt; end
        rst_low_now = !wd_rst_n_o;
    endtask

    function automatic bit ptick();
        tph = (tph + 1) % 3;
        return (tph == 0);
    endfunction

    task automatic drive(input bit fc, input bit tk);
        freq_chg = fc;
        tick     = tk;
        if (tk) begin
            tk_cnt++;
            if (rst_low_now) pulse_ticks++;
        end
    endtask

    task automatic run(input int n);
        repeat (n) begin nxt(); drive(0, ptick()); end
    endtask

    task automatic start_chg();
        nxt();
        drive(1, ptick());
        t0 = tk_cnt;
    endtask

    task automatic wait_last_tick();
        forever begin
            nxt();
            if (m_run && m_left == 1) break;
            drive(0, ptick());
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        nxt();
        check("R10 reset alarm", int'(alarm_o), 0);
        check("R10 reset pulse idle", int'(wd_rst_n_o), 1);
        check("R10 reset strobe", int'(restore_stb_o), 0);
        check("R10 reset source", int'(restore_sw_o), 0);
        drive(0, ptick());

        // R1: disarmed
        tmo_sel = 0; n_stb = 0;
        start_chg(); run(40);
        check("R1 no expiry when disarmed", n_stb, 0);
        check("R1 no alarm when disarmed", int'(alarm_o), 0);

        // R2 R4 R7: expiry, software source
        tmo_sel = 2; recov = 1; n_stb = 0; pulse_ticks = 0;
        start_chg(); run(60);
        check("R2 expiry count", n_stb, 1);
        check("R2 ticks to expiry", t_exp - t0, 2 * TPU);
        check("R4 alarm set", int'(alarm_o), 1);
        check("R4 pulse length in ticks", pulse_ticks, RT);
        check("R4 pulse ended", int'(wd_rst_n_o), 1);
        check("R7 source software", int'(restore_sw_o), 1);
        tmo_sel = 0; run(2);
        check("R5 alarm cleared", int'(alarm_o), 0);

        // R7: strap source
        tmo_sel = 1; recov = 0; n_stb = 0;
        start_chg(); run(40);
        check("R7 expiry count", n_stb, 1);
        check("R7 source strap", int'(restore_sw_o), 0);
        tmo_sel = 0; run(2);

        // R3: cancel
        tmo_sel = 3; n_stb = 0;
        start_chg(); run(10);
        tmo_sel = 0; run(60);
        check("R3 cancel no expiry", n_stb, 0);
        check("R3 cancel no alarm", int'(alarm_o), 0);
        check("R3 cancel no pulse", int'(wd_rst_n_o), 1);

        // R6: reload edge, then held high
        tmo_sel = 1; recov = 1; n_stb = 0;
        start_chg(); wait_last_tick();
        reload = 1; drive(0, ptick()); t0 = tk_cnt;
        run(60);
        check("R6 reload expiry count", n_stb, 1);
        check("R6 reload full restart", t_exp - t0, TPU);
        reload = 0; tmo_sel = 0; run(2);
        tmo_sel = 1; n_stb = 0; run(1);
        reload = 1; run(30);
        check("R6 idle reload no start", n_stb, 0);
        reload = 0; tmo_sel = 0; run(2);

        // R8: change on the final tick
        tmo_sel = 1; n_stb = 0;
        start_chg(); wait_last_tick();
        drive(1, 1); t0 = tk_cnt;
        nxt();
        check("R8 no expiry on collision", n_stb, 0);
        drive(0, ptick()); run(60);
        check("R8 collision expiry count", n_stb, 1);
        check("R8 collision full restart", t_exp - t0, TPU);
        tmo_sel = 0; run(2);

        // R8: mid-count change
        tmo_sel = 2; n_stb = 0;
        start_chg(); run(9);
        nxt(); drive(1, ptick()); t0 = tk_cnt;
        run(60);
        check("R8 mid restart count", n_stb, 1);
        check("R8 mid restart ticks", t_exp - t0, 2 * TPU);
        tmo_sel = 0; run(2);

        // R9: re-arm required after expiry
        tmo_sel = 1; n_stb = 0;
        start_chg(); run(40);
        start_chg(); run(40);
        check("R9 change ignored in alarm", n_stb, 1);
        tmo_sel = 0; run(2);
        tmo_sel = 1;
        start_chg(); run(40);
        check("R9 rearmed expiry", n_stb, 2);
        tmo_sel = 0; run(4);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule